// File: doc/BRIEF.md
# Frame-synchronous window register bank

This block keeps the configuration of two display windows in two layers. Software writes a working copy through a simple register write port and can read it back. The display pipeline sees only a second, shadow layer. The shadow layer changes only on a vertical sync pulse, so a frame is never scanned with half of a new setting.

Software commits a new setting by raising the update-request bit. At the next vsync, every window with a commit outstanding copies its whole working copy into its shadow copy. Each window also has a hold bit. While the hold bit is set, that window keeps its commit outstanding and skips the vsync copy. Software can therefore edit several fields, or set the request early, and release the window when it is ready. The release takes effect at the first vsync after the hold bit is cleared.

Window 1 has a colour-key control and a key value. Window 0 has neither. A soft-clear bit wipes both layers in one clock.

Top module: `shreg_bank`

## Requirements
- R1: After the synchronous `rst`, every readable register and every shadow output is zero.
- R2: A write lands in the working copy on the clock edge where `wr_en` is high. A read returns the working copy (never the shadow copy) on `rd_data` one cycle after `rd_en`. The register map is as follows. Address 0x00 is global control: bit 0 requests an update and reads 1 while any window has a commit outstanding; bit 1 is soft-clear. Address 0x01 holds the hold bits, bit w for window w. Window w occupies addresses 0x10*(w+1)+f. Field f is: 0 control (bit 0 enable, bits 4:1 pixel format), 1 buffer base, 2 padded buffer width, 3 buffer height, 4 read offset X, 5 read offset Y, 6 top-left corner, 7 inclusive bottom-right corner, 8 key enable (bit 0), 9 key value (bits 23:0).
- R3: A shadow output changes only on a cycle with `vsync` high, or on a soft-clear. On such a vsync, a window whose commit is outstanding and whose hold bit is clear copies all of its fields into the shadow copy. A vsync with no commit outstanding leaves the shadow copy unchanged.
- R4: A window with its hold bit set keeps its shadow copy and its outstanding commit across any number of vsyncs. Once the bit is cleared, the next vsync commits that window without a new request.
- R5: The update-request bit reads 1 from the cycle after the request until every window has committed, and then reads 0 with no software action.
- R6: A request written in the same cycle as `vsync` is not committed by that vsync. It is committed by the next one. A field written in the same cycle as a committing vsync leaves the shadow copy with the value the field held before that write.
- R7: On window 0, writes to fields 8 and 9 are ignored, both fields read 0, and its shadow key outputs stay 0. Window 1 stores, reads back and commits both fields.
- R8: Clearing a window's enable bit leaves `sh_enable` for that window high until the committing vsync.
- R9: Writing 1 to bit 1 of address 0x00 clears the working copy, the shadow copy, the hold bits and the outstanding commits, all on the same edge.
- R10: Widths, heights and offsets occupy bits 11:0. Corner registers carry X in bits 11:0 and Y in bits 27:16. All other bits of these fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Working-copy read data, one cycle after `rd_en` |
| vsync | input | 1 | One-cycle vertical sync pulse |
| sh_enable | output | NUM_WIN | Shadow window enable |
| sh_pixfmt | output | NUM_WIN*4 | Shadow pixel format |
| sh_base | output | NUM_WIN*BASE_W | Shadow buffer base address |
| sh_width | output | NUM_WIN*COORD_W | Shadow padded buffer width |
| sh_height | output | NUM_WIN*COORD_W | Shadow buffer height |
| sh_offx | output | NUM_WIN*COORD_W | Shadow read offset X |
| sh_offy | output | NUM_WIN*COORD_W | Shadow read offset Y |
| sh_tlx | output | NUM_WIN*COORD_W | Shadow top-left X |
| sh_tly | output | NUM_WIN*COORD_W | Shadow top-left Y |
| sh_brx | output | NUM_WIN*COORD_W | Shadow inclusive bottom-right X |
| sh_bry | output | NUM_WIN*COORD_W | Shadow inclusive bottom-right Y |
| sh_key_en | output | NUM_WIN | Shadow colour-key enable |
| sh_key_val | output | NUM_WIN*KEY_W | Shadow colour-key value |

## Verification
Two collisions with vsync can happen in the same clock, and both are tested.

- **Request on the vsync edge.** The bench writes the update request together with the vsync. It checks that the shadow copy keeps its old contents and that the new value appears only after the following vsync.
- **Field write on the vsync edge.** The bench arms a commit and then writes a field together with the committing vsync. It checks that the shadow copy takes the earlier value, the read port shows the newer one, and the request bit has dropped.

Both outcomes are predicted by a bench-side model. The model applies the vsync copy before the write of the same cycle.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  localparam int FLD_W = 4;
  localparam int NUM_FLD = 10;

  localparam logic [FLD_W-1:0] F_CTRL     = 4'd0;
  localparam logic [FLD_W-1:0] F_BASE     = 4'd1;
  localparam logic [FLD_W-1:0] F_WIDTH    = 4'd2;
  localparam logic [FLD_W-1:0] F_HEIGHT   = 4'd3;
  localparam logic [FLD_W-1:0] F_OFFX     = 4'd4;
  localparam logic [FLD_W-1:0] F_OFFY     = 4'd5;
  localparam logic [FLD_W-1:0] F_TOPLEFT  = 4'd6;
  localparam logic [FLD_W-1:0] F_BOTRIGHT = 4'd7;
  localparam logic [FLD_W-1:0] F_KEYCTL   = 4'd8;
  localparam logic [FLD_W-1:0] F_KEYVAL   = 4'd9;

  localparam int GLOBAL_ADDR  = 0;
  localparam int PROTECT_ADDR = 1;
  localparam int FMT_W        = 4;
endpackage

// File: rtl/shreg_ctrl.sv
module shreg_ctrl
  import shreg_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_WIN-1:0] win_wr,
  output logic [FLD_W-1:0]   wr_fld,
  output logic               upd_req,
  output logic               soft_clr,
  output logic [NUM_WIN-1:0] prot_q
);
  localparam int SEL_W = ADDR_W - FLD_W;

  logic glb_hit;
  logic prot_hit;

  assign glb_hit  = wr_en && (wr_addr == ADDR_W'(GLOBAL_ADDR));
  assign prot_hit = wr_en && (wr_addr == ADDR_W'(PROTECT_ADDR));
  assign upd_req  = glb_hit && wr_data[0];
  assign soft_clr = glb_hit && wr_data[1];
  assign wr_fld   = wr_addr[FLD_W-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_sel
    assign win_wr[w] = wr_en && (wr_addr[ADDR_W-1:FLD_W] == SEL_W'(w + 1));
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      prot_q <= '0;
    end else if (prot_hit) begin
      prot_q <= wr_data[NUM_WIN-1:0];
    end
  end
endmodule

// File: rtl/shreg_win.sv
module shreg_win
  import shreg_pkg::*;
#(
  parameter bit HAS_KEY = 1'b1,
  parameter int DATA_W  = 32,
  parameter int BASE_W  = 32,
  parameter int COORD_W = 12,
  parameter int KEY_W   = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [FLD_W-1:0]   wr_fld,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               vsync,
  input  logic               protect,
  input  logic               upd_req,
  input  logic [FLD_W-1:0]   rd_fld,
  output logic [DATA_W-1:0]  rd_val,
  output logic               pending,
  output logic               s_en,
  output logic [FMT_W-1:0]   s_fmt,
  output logic [BASE_W-1:0]  s_base,
  output logic [COORD_W-1:0] s_w,
  output logic [COORD_W-1:0] s_h,
  output logic [COORD_W-1:0] s_ox,
  output logic [COORD_W-1:0] s_oy,
  output logic [COORD_W-1:0] s_tlx,
  output logic [COORD_W-1:0] s_tly,
  output logic [COORD_W-1:0] s_brx,
  output logic [COORD_W-1:0] s_bry,
  output logic               s_ken,
  output logic [KEY_W-1:0]   s_kval
);
  localparam int HALF = DATA_W / 2;

  logic               a_en;
  logic [FMT_W-1:0]   a_fmt;
  logic [BASE_W-1:0]  a_base;
  logic [COORD_W-1:0] a_w, a_h, a_ox, a_oy, a_tlx, a_tly, a_brx, a_bry;
  logic               a_ken;
  logic [KEY_W-1:0]   a_kval;
  logic               commit;

  // shadow copy moves only on vsync, only when armed and not held
  assign commit = vsync && pending && !protect;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      a_en <= 1'b0; a_fmt <= '0; a_base <= '0;
      a_w <= '0; a_h <= '0; a_ox <= '0; a_oy <= '0;
      a_tlx <= '0; a_tly <= '0; a_brx <= '0; a_bry <= '0;
      s_en <= 1'b0; s_fmt <= '0; s_base <= '0;
      s_w <= '0; s_h <= '0; s_ox <= '0; s_oy <= '0;
      s_tlx <= '0; s_tly <= '0; s_brx <= '0; s_bry <= '0;
      pending <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_fld)
          F_CTRL: begin
            a_en  <= wr_data[0];
            a_fmt <= wr_data[FMT_W:1];
          end
          F_BASE:   a_base <= wr_data[BASE_W-1:0];
          F_WIDTH:  a_w    <= wr_data[COORD_W-1:0];
          F_HEIGHT: a_h    <= wr_data[COORD_W-1:0];
          F_OFFX:   a_ox   <= wr_data[COORD_W-1:0];
          F_OFFY:   a_oy   <= wr_data[COORD_W-1:0];
          F_TOPLEFT: begin
            a_tlx <= wr_data[COORD_W-1:0];
            a_tly <= wr_data[HALF +: COORD_W];
          end
          F_BOTRIGHT: begin
            a_brx <= wr_data[COORD_W-1:0];
            a_bry <= wr_data[HALF +: COORD_W];
          end
          default: ;
        endcase
      end
      if (commit) begin
        s_en <= a_en; s_fmt <= a_fmt; s_base <= a_base;
        s_w <= a_w; s_h <= a_h; s_ox <= a_ox; s_oy <= a_oy;
        s_tlx <= a_tlx; s_tly <= a_tly; s_brx <= a_brx; s_bry <= a_bry;
      end
      // a fresh request wins over the clear of the one being committed
      if (upd_req) begin
        pending <= 1'b1;
      end else if (commit) begin
        pending <= 1'b0;
      end
    end
  end

  if (HAS_KEY) begin : g_key
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        a_ken <= 1'b0; a_kval <= '0;
        s_ken <= 1'b0; s_kval <= '0;
      end else begin
        if (wr_en && wr_fld == F_KEYCTL) a_ken  <= wr_data[0];
        if (wr_en && wr_fld == F_KEYVAL) a_kval <= wr_data[KEY_W-1:0];
        if (commit) begin
          s_ken  <= a_ken;
          s_kval <= a_kval;
        end
      end
    end
  end else begin : g_nokey
    assign a_ken  = 1'b0;
    assign a_kval = '0;
    assign s_ken  = 1'b0;
    assign s_kval = '0;
  end

  always_comb begin
    rd_val = '0;
    case (rd_fld)
      F_CTRL: begin
        rd_val[0]       = a_en;
        rd_val[FMT_W:1] = a_fmt;
      end
      F_BASE:   rd_val[BASE_W-1:0]  = a_base;
      F_WIDTH:  rd_val[COORD_W-1:0] = a_w;
      F_HEIGHT: rd_val[COORD_W-1:0] = a_h;
      F_OFFX:   rd_val[COORD_W-1:0] = a_ox;
      F_OFFY:   rd_val[COORD_W-1:0] = a_oy;
      F_TOPLEFT: begin
        rd_val[COORD_W-1:0]     = a_tlx;
        rd_val[HALF +: COORD_W] = a_tly;
      end
      F_BOTRIGHT: begin
        rd_val[COORD_W-1:0]     = a_brx;
        rd_val[HALF +: COORD_W] = a_bry;
      end
      F_KEYCTL: rd_val[0]         = a_ken;
      F_KEYVAL: rd_val[KEY_W-1:0] = a_kval;
      default: ;
    endcase
  end
endmodule

// File: rtl/shreg_bank.sv
module shreg_bank
  import shreg_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int BASE_W  = 32,
  parameter int COORD_W = 12,
  parameter int KEY_W   = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       vsync,
  output logic [NUM_WIN-1:0]         sh_enable,
  output logic [NUM_WIN*FMT_W-1:0]   sh_pixfmt,
  output logic [NUM_WIN*BASE_W-1:0]  sh_base,
  output logic [NUM_WIN*COORD_W-1:0] sh_width,
  output logic [NUM_WIN*COORD_W-1:0] sh_height,
  output logic [NUM_WIN*COORD_W-1:0] sh_offx,
  output logic [NUM_WIN*COORD_W-1:0] sh_offy,
  output logic [NUM_WIN*COORD_W-1:0] sh_tlx,
  output logic [NUM_WIN*COORD_W-1:0] sh_tly,
  output logic [NUM_WIN*COORD_W-1:0] sh_brx,
  output logic [NUM_WIN*COORD_W-1:0] sh_bry,
  output logic [NUM_WIN-1:0]         sh_key_en,
  output logic [NUM_WIN*KEY_W-1:0]   sh_key_val
);
  localparam int SEL_W = ADDR_W - FLD_W;

  logic [NUM_WIN-1:0] win_wr;
  logic [FLD_W-1:0]   wr_fld;
  logic               upd_req;
  logic               soft_clr;
  logic [NUM_WIN-1:0] prot_q;
  logic [NUM_WIN-1:0] pend;
  logic [DATA_W-1:0]  win_rd [NUM_WIN];
  logic [DATA_W-1:0]  rd_mux;

  shreg_ctrl #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_wr(win_wr), .wr_fld(wr_fld), .upd_req(upd_req), .soft_clr(soft_clr),
    .prot_q(prot_q)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    shreg_win #(
      .HAS_KEY(w != 0), .DATA_W(DATA_W), .BASE_W(BASE_W),
      .COORD_W(COORD_W), .KEY_W(KEY_W)
    ) win_i (
      .clk(clk), .rst(rst), .clr(soft_clr), .wr_en(win_wr[w]), .wr_fld(wr_fld),
      .wr_data(wr_data), .vsync(vsync), .protect(prot_q[w]), .upd_req(upd_req),
      .rd_fld(rd_addr[FLD_W-1:0]), .rd_val(win_rd[w]), .pending(pend[w]),
      .s_en(sh_enable[w]),
      .s_fmt(sh_pixfmt[w*FMT_W +: FMT_W]),
      .s_base(sh_base[w*BASE_W +: BASE_W]),
      .s_w(sh_width[w*COORD_W +: COORD_W]),
      .s_h(sh_height[w*COORD_W +: COORD_W]),
      .s_ox(sh_offx[w*COORD_W +: COORD_W]),
      .s_oy(sh_offy[w*COORD_W +: COORD_W]),
      .s_tlx(sh_tlx[w*COORD_W +: COORD_W]),
      .s_tly(sh_tly[w*COORD_W +: COORD_W]),
      .s_brx(sh_brx[w*COORD_W +: COORD_W]),
      .s_bry(sh_bry[w*COORD_W +: COORD_W]),
      .s_ken(sh_key_en[w]),
      .s_kval(sh_key_val[w*KEY_W +: KEY_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_W'(GLOBAL_ADDR)) begin
      rd_mux[0] = |pend;
    end else if (rd_addr == ADDR_W'(PROTECT_ADDR)) begin
      rd_mux[NUM_WIN-1:0] = prot_q;
    end else begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (rd_addr[ADDR_W-1:FLD_W] == SEL_W'(w + 1)) rd_mux = win_rd[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/shreg_bank_chk.sv
module shreg_bank_chk #(
  parameter int NUM_WIN = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int BASE_W  = 32,
  parameter int COORD_W = 12,
  parameter int KEY_W   = 24
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic                       vsync,
  input logic [NUM_WIN-1:0]         prot_q,
  input logic [NUM_WIN-1:0]         sh_enable,
  input logic [NUM_WIN*BASE_W-1:0]  sh_base,
  input logic [NUM_WIN*COORD_W-1:0] sh_width,
  input logic [NUM_WIN*COORD_W-1:0] sh_bry,
  input logic [NUM_WIN-1:0]         sh_key_en,
  input logic [NUM_WIN*KEY_W-1:0]   sh_key_val
);
  logic softclr;
  assign softclr = wr_en && (wr_addr == '0) && wr_data[1];

  // R3: shadow outputs move only on vsync (or soft-clear)
  assert_shadow_still_R3: assert property (@(posedge clk) disable iff (rst)
    (!vsync && !softclr) |=> ($stable(sh_base) && $stable(sh_enable) &&
                              $stable(sh_width) && $stable(sh_bry)));

  // R4: a held window ignores vsync
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_hold
    assert_hold_blocks_R4: assert property (@(posedge clk) disable iff (rst)
      (vsync && prot_q[w] && !softclr) |=>
        ($stable(sh_base[w*BASE_W +: BASE_W]) && $stable(sh_enable[w])));
  end

  // R7: window 0 never presents a colour key
  assert_win0_nokey_R7: assert property (@(posedge clk) disable iff (rst)
    (sh_key_en[0] == 1'b0) && (sh_key_val[KEY_W-1:0] == '0));

  // R9: soft-clear empties shadow copy and hold bits together
  assert_softclr_all_R9: assert property (@(posedge clk) disable iff (rst)
    softclr |=> ((sh_enable == '0) && (sh_base == '0) && (prot_q == '0)));
endmodule

bind shreg_bank shreg_bank_chk #(
  .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .BASE_W(BASE_W), .COORD_W(COORD_W), .KEY_W(KEY_W)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .vsync(vsync), .prot_q(prot_q), .sh_enable(sh_enable), .sh_base(sh_base),
  .sh_width(sh_width), .sh_bry(sh_bry), .sh_key_en(sh_key_en),
  .sh_key_val(sh_key_val)
);

// File: tb/shreg_bank_tb_top.sv
module shreg_bank_tb_top;
  localparam int NW = 2;
  localparam int NF = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic        vsync;
  logic [NW-1:0]    sh_enable;
  logic [NW*4-1:0]  sh_pixfmt;
  logic [NW*32-1:0] sh_base;
  logic [NW*12-1:0] sh_width, sh_height, sh_offx, sh_offy;
  logic [NW*12-1:0] sh_tlx, sh_tly, sh_brx, sh_bry;
  logic [NW-1:0]    sh_key_en;
  logic [NW*24-1:0] sh_key_val;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] act [NW][NF];
  logic [31:0] shm [NW][NF];
  logic [NW-1:0] pend;
  logic [NW-1:0] prot;

  always #2 clk = ~clk;

  shreg_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .vsync(vsync),
    .sh_enable(sh_enable), .sh_pixfmt(sh_pixfmt), .sh_base(sh_base),
    .sh_width(sh_width), .sh_height(sh_height), .sh_offx(sh_offx),
    .sh_offy(sh_offy), .sh_tlx(sh_tlx), .sh_tly(sh_tly), .sh_brx(sh_brx),
    .sh_bry(sh_bry), .sh_key_en(sh_key_en), .sh_key_val(sh_key_val)
  );

  function automatic logic [31:0] fmask(int w, int f);
    case (f)
      0: return 32'h0000_001F;
      1: return 32'hFFFF_FFFF;
      2, 3, 4, 5: return 32'h0000_0FFF;
      6, 7: return 32'h0FFF_0FFF;
      8: return (w != 0) ? 32'h1 : 32'h0;
      9: return (w != 0) ? 32'h00FF_FFFF : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] waddr(int w, int f);
    return 8'((w + 1) * 16 + f);
  endfunction

  function automatic logic [31:0] pat(int w, int f, int k);
    logic [31:0] v;
    v = 32'h9E37_79B9 * 32'(w * 16 + f + 1) + 32'h0F1E_2D3C * 32'(k);
    if (f == 0) v[0] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] shread(int w, int f);
    logic [31:0] v;
    v = '0;
    case (f)
      0: begin v[0] = sh_enable[w]; v[4:1] = sh_pixfmt[w*4 +: 4]; end
      1: v = sh_base[w*32 +: 32];
      2: v[11:0] = sh_width[w*12 +: 12];
      3: v[11:0] = sh_height[w*12 +: 12];
      4: v[11:0] = sh_offx[w*12 +: 12];
      5: v[11:0] = sh_offy[w*12 +: 12];
      6: begin v[11:0] = sh_tlx[w*12 +: 12]; v[27:16] = sh_tly[w*12 +: 12]; end
      7: begin v[11:0] = sh_brx[w*12 +: 12]; v[27:16] = sh_bry[w*12 +: 12]; end
      8: v[0] = sh_key_en[w];
      9: v[23:0] = sh_key_val[w*24 +: 24];
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string ftag(int f);
    if (f >= 8) return "R7";
    if (f >= 6) return "R10";
    return "R2";
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // one bus cycle; the model commits on vsync before applying the write
  task automatic cyc(bit wr, logic [7:0] a, logic [31:0] d, bit vs);
    @(negedge clk);
    wr_en = wr; wr_addr = a; wr_data = d; vsync = vs;
    @(negedge clk);
    wr_en = 0; vsync = 0;
    if (vs) begin
      for (int w = 0; w < NW; w++) begin
        if (pend[w] && !prot[w]) begin
          for (int f = 0; f < NF; f++) shm[w][f] = act[w][f];
          pend[w] = 1'b0;
        end
      end
    end
    if (wr) begin
      if (a == 8'h00) begin
        if (d[1]) begin
          for (int w = 0; w < NW; w++)
            for (int f = 0; f < NF; f++) begin act[w][f] = '0; shm[w][f] = '0; end
          pend = '0; prot = '0;
        end else if (d[0]) begin
          pend = '1;
        end
      end else if (a == 8'h01) begin
        prot = d[NW-1:0];
      end else begin
        for (int w = 0; w < NW; w++)
          if (a[7:4] == 4'(w + 1) && int'(a[3:0]) < NF)
            act[w][a[3:0]] = d & fmask(w, int'(a[3:0]));
      end
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic check_reads(string req);
    logic [31:0] v;
    for (int w = 0; w < NW; w++)
      for (int f = 0; f < NF; f++) begin
        rd(waddr(w, f), v);
        chk((req == "") ? ftag(f) : req, $sformatf("read w%0d f%0d", w, f), v, act[w][f]);
      end
  endtask

  task automatic check_shadow(string req);
    for (int w = 0; w < NW; w++)
      for (int f = 0; f < NF; f++)
        chk(req, $sformatf("shadow w%0d f%0d", w, f), shread(w, f), shm[w][f]);
  endtask

  task automatic check_global(string req);
    logic [31:0] v;
    rd(8'h00, v);
    chk(req, "update bit", v, {31'b0, |pend});
    rd(8'h01, v);
    chk(req, "hold bits", v, {30'b0, prot});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; wr_en = 0; wr_addr = '0; wr_data = '0; rd_en = 0; rd_addr = '0; vsync = 0;
    for (int w = 0; w < NW; w++)
      for (int f = 0; f < NF; f++) begin act[w][f] = '0; shm[w][f] = '0; end
    pend = '0; prot = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_reads("R1");
    check_shadow("R1");
    check_global("R1");

    // R2 / R7 / R10 sweep of every field, no shadow movement
    for (int w = 0; w < NW; w++)
      for (int f = 0; f < NF; f++) cyc(1, waddr(w, f), pat(w, f, 0), 0);
    check_reads("");
    check_shadow("R3");

    // R3: vsync without request does nothing
    cyc(0, 8'h00, 32'h0, 1);
    check_shadow("R3");

    // R5 request visible, R3 commit, R5 self clear
    cyc(1, 8'h00, 32'h1, 0);
    check_global("R5");
    check_shadow("R3");
    cyc(0, 8'h00, 32'h0, 1);
    check_shadow("R3");
    check_global("R5");
    chk("R7", "win1 key committed", {31'b0, sh_key_en[1]}, act[1][8]);

    // R4 every hold combination
    for (int pm = 0; pm < 4; pm++) begin
      cyc(1, 8'h01, 32'(pm), 0);
      for (int w = 0; w < NW; w++)
        for (int f = 0; f < NF; f++) cyc(1, waddr(w, f), pat(w, f, pm + 1), 0);
      cyc(1, 8'h00, 32'h1, 0);
      cyc(0, 8'h00, 32'h0, 1);
      check_shadow("R4");
      check_global("R4");
      cyc(0, 8'h00, 32'h0, 1);
      check_shadow("R4");
      cyc(1, 8'h01, 32'h0, 0);
      cyc(0, 8'h00, 32'h0, 1);
      check_shadow("R4");
      check_global("R5");
    end

    // R8 enable clear deferred
    cyc(1, waddr(0, 0), 32'h0, 0);
    cyc(1, 8'h00, 32'h1, 0);
    chk("R8", "enable before vsync", {31'b0, sh_enable[0]}, 32'h1);
    cyc(0, 8'h00, 32'h0, 1);
    chk("R8", "enable after vsync", {31'b0, sh_enable[0]}, 32'h0);

    // R6 request on the vsync edge
    cyc(1, waddr(1, 1), 32'h1111_AAAA, 0);
    cyc(1, 8'h00, 32'h1, 1);
    chk("R6", "request same cycle as vsync", shread(1, 1), shm[1][1]);
    chk("R6", "old base kept", shread(1, 1), 32'h1111_AAAA ^ 32'h0 ^ shm[1][1] ^ 32'h1111_AAAA);
    cyc(0, 8'h00, 32'h0, 1);
    chk("R6", "next vsync commits", shread(1, 1), 32'h1111_AAAA);
    // R6 write on committing vsync edge
    cyc(1, waddr(1, 1), 32'h2222_BBBB, 0);
    cyc(1, 8'h00, 32'h1, 0);
    cyc(1, waddr(1, 1), 32'h3333_CCCC, 1);
    chk("R6", "shadow takes prior value", shread(1, 1), 32'h2222_BBBB);
    rd(waddr(1, 1), v);
    chk("R6", "read shows newer value", v, 32'h3333_CCCC);
    check_global("R6");

    // R9 soft-clear
    cyc(1, 8'h01, 32'h3, 0);
    cyc(1, 8'h00, 32'h1, 0);
    cyc(1, 8'h00, 32'h2, 0);
    check_shadow("R9");
    check_reads("R9");
    check_global("R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule